// File: doc/BRIEF.md
# Timer Interrupt Status and End-of-Interrupt Unit

This block sits inside a small interrupt controller. It keeps one pending flag for each timer interrupt source. It also keeps the in-service flags for those sources and a flag that suspends the DMA engine. A timer request pulse sets its pending flag. When the CPU acknowledges an interrupt type that belongs to a timer, that source's pending flag drops and its in-service flag rises on the same clock edge.

Software clears in-service flags by writing a command word. A command with the top bit set clears the highest-priority in-service flag that is active. A command with the top bit clear clears the flag of the source whose interrupt type is in the low five bits.

When the CPU takes a non-maskable interrupt, the DMA suspend flag is set by hardware. Software can read that flag and write it back through the status word.

Top module: `isc_status_eoi`

## Requirements
- R1: After reset, all pending flags, all in-service flags and the DMA suspend flag are 0. Both readable words read 0.
- R2: A high `tmr_req[i]` in a cycle makes `pend[i]` read 1 after the next clock edge. Any combination of sources may be pending at once.
- R3: An acknowledge whose type equals `TMR_TYPE_BASE + i` (type 8 + i by default) clears `pend[i]` and sets `insvc[i]` on the same edge. An acknowledge of any other type changes nothing.
- R4: If a request and an acknowledge for the same source arrive in the same cycle, the pending flag stays 1.
- R5: A command write (`reg_sel`=1) with bit 15 = 0 clears only the in-service flag whose type is in bits 4:0.
- R6: A command with bit 15 = 0 whose type maps to no timer source leaves every in-service flag unchanged.
- R7: A command with bit 15 = 1 clears the lowest-index in-service flag that is set. If no flag is set, it has no effect.
- R8: A high `nmi_taken` sets `dma_halt` after the next edge. The flag is visible at bit 15 of the status word.
- R9: A status write (`reg_sel`=0) loads bit 15 into the DMA suspend flag. A simultaneous `nmi_taken` wins and leaves the flag at 1. All other bits of a status write are ignored, so the pending flags are not affected.
- R10: The status word reads the pending flags at bits 0 to NUM_TMR-1 and the DMA suspend flag at bit 15. All other bits read 0.
- R11: The command word reads back bit 15 and bits 4:0 of the last command written. All other bits read 0.
- R12: If an acknowledge sets an in-service flag on the same edge that a command clears it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_req | input | NUM_TMR | One request pulse per timer source |
| nmi_taken | input | 1 | Strobe that marks a taken non-maskable interrupt |
| ack_stb | input | 1 | Interrupt acknowledge strobe |
| ack_type | input | TYPE_W | Interrupt type being acknowledged |
| reg_sel | input | 1 | Word select: 0 = status, 1 = command |
| reg_wr | input | 1 | Write enable for the selected word |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected word (combinational) |
| pend | output | NUM_TMR | Pending flags |
| insvc | output | NUM_TMR | In-service flags |
| dma_halt | output | 1 | DMA suspend request |

## Verification
On every cycle, the checker confirms several things: requests land in the pending flags, acknowledges move a source from pending to in-service, a nonspecific command strips exactly the lowest set in-service flag, an out-of-range specific command leaves the in-service flags unchanged, a non-maskable interrupt raises the suspend flag, and reserved read bits stay zero. The bench's scenarios cover the rest: every request pattern, all 32 command types, and every starting in-service pattern under a nonspecific command. They also cover the same-cycle collisions (request against acknowledge, acknowledge against clear, NMI against software write) and the exact readback of both words.

// File: rtl/isc_pkg.sv
package isc_pkg;
   typedef enum logic {
      REG_STATUS = 1'b0,
      REG_CMD    = 1'b1
   } isc_reg_e;
endpackage

// File: rtl/isc_pending.sv
module isc_pending #(
   parameter int NUM_TMR = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_TMR-1:0] req,
   input  logic [NUM_TMR-1:0] clr,
   output logic [NUM_TMR-1:0] pend
);
   for (genvar i = 0; i < NUM_TMR; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      pend[i] <= 1'b0;
         else if (req[i]) pend[i] <= 1'b1;   // new request beats acknowledge
         else if (clr[i]) pend[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/isc_inservice.sv
module isc_inservice #(
   parameter int NUM_TMR       = 3,
   parameter int TYPE_W        = 5,
   parameter int TMR_TYPE_BASE = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ack_stb,
   input  logic [TYPE_W-1:0]  ack_type,
   input  logic               cmd_wr,
   input  logic               cmd_nspec,
   input  logic [TYPE_W-1:0]  cmd_type,
   output logic [NUM_TMR-1:0] ack_hit,
   output logic [NUM_TMR-1:0] insvc
);
   logic [NUM_TMR-1:0] spec_hit;
   logic [NUM_TMR-1:0] lowest;
   logic [NUM_TMR-1:0] clr;

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_dec
      localparam logic [TYPE_W-1:0] SRC_TYPE = TYPE_W'(TMR_TYPE_BASE + i);
      assign ack_hit[i]  = ack_stb && (ack_type == SRC_TYPE);
      assign spec_hit[i] = (cmd_type == SRC_TYPE);
   end

   // fixed priority: the lowest index wins
   assign lowest = insvc & (~insvc + NUM_TMR'(1));

   always_comb begin
      clr = '0;
      if (cmd_wr) clr = cmd_nspec ? lowest : spec_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) insvc <= '0;
      else        insvc <= (insvc & ~clr) | ack_hit;
   end
endmodule

// File: rtl/isc_halt.sv
module isc_halt (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_taken,
   input  logic sw_wr,
   input  logic sw_val,
   output logic halt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         halt <= 1'b0;
      else if (nmi_taken) halt <= 1'b1;
      else if (sw_wr)     halt <= sw_val;
   end
endmodule

// File: rtl/isc_status_eoi.sv
module isc_status_eoi #(
   parameter int NUM_TMR       = 3,
   parameter int TYPE_W        = 5,
   parameter int TMR_TYPE_BASE = 8,
   parameter int DATA_W        = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_TMR-1:0] tmr_req,
   input  logic               nmi_taken,
   input  logic               ack_stb,
   input  logic [TYPE_W-1:0]  ack_type,
   input  logic               reg_sel,
   input  logic               reg_wr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic [NUM_TMR-1:0] pend,
   output logic [NUM_TMR-1:0] insvc,
   output logic               dma_halt
);
   import isc_pkg::*;

   localparam int TOP_BIT = DATA_W - 1;

   if (NUM_TMR < 1 || NUM_TMR > DATA_W - 1) begin : g_bad_num
      $error("NUM_TMR must fit below the top status bit");
   end
   if (TYPE_W >= DATA_W - 1) begin : g_bad_type
      $error("TYPE_W must leave room for the nonspecific flag");
   end
   if (TMR_TYPE_BASE < 0 || TMR_TYPE_BASE + NUM_TMR > (1 << TYPE_W)) begin : g_bad_base
      $error("timer types must fit in the type field");
   end

   isc_reg_e            sel;
   logic                cmd_wr;
   logic                stat_wr;
   logic                cmd_nspec_q;
   logic [TYPE_W-1:0]   cmd_type_q;
   logic [NUM_TMR-1:0]  ack_hit;
   logic                rsv_unused;

   assign sel        = isc_reg_e'(reg_sel);
   assign cmd_wr     = reg_wr && (sel == REG_CMD);
   assign stat_wr    = reg_wr && (sel == REG_STATUS);
   assign rsv_unused = ^reg_wdata[TOP_BIT-1:TYPE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_nspec_q <= 1'b0;
         cmd_type_q  <= '0;
      end else if (cmd_wr) begin
         cmd_nspec_q <= reg_wdata[TOP_BIT];
         cmd_type_q  <= reg_wdata[TYPE_W-1:0];
      end
   end

   isc_inservice #(
      .NUM_TMR      (NUM_TMR),
      .TYPE_W       (TYPE_W),
      .TMR_TYPE_BASE(TMR_TYPE_BASE)
   ) u_insvc (
      .clk      (clk),
      .rst_n    (rst_n),
      .ack_stb  (ack_stb),
      .ack_type (ack_type),
      .cmd_wr   (cmd_wr),
      .cmd_nspec(reg_wdata[TOP_BIT]),
      .cmd_type (reg_wdata[TYPE_W-1:0]),
      .ack_hit  (ack_hit),
      .insvc    (insvc)
   );

   isc_pending #(.NUM_TMR(NUM_TMR)) u_pend (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (tmr_req),
      .clr  (ack_hit),
      .pend (pend)
   );

   isc_halt u_halt (
      .clk      (clk),
      .rst_n    (rst_n),
      .nmi_taken(nmi_taken),
      .sw_wr    (stat_wr),
      .sw_val   (reg_wdata[TOP_BIT]),
      .halt     (dma_halt)
   );

   always_comb begin
      reg_rdata = '0;
      if (sel == REG_STATUS) begin
         reg_rdata[NUM_TMR-1:0] = pend;
         reg_rdata[TOP_BIT]     = dma_halt;
      end else begin
         reg_rdata[TYPE_W-1:0]  = cmd_type_q;
         reg_rdata[TOP_BIT]     = cmd_nspec_q;
      end
   end
endmodule

// File: rtl/isc_status_eoi_chk.sv
module isc_status_eoi_chk #(
   parameter int NUM_TMR       = 3,
   parameter int TYPE_W        = 5,
   parameter int TMR_TYPE_BASE = 8,
   parameter int DATA_W        = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_TMR-1:0] tmr_req,
   input logic               nmi_taken,
   input logic               ack_stb,
   input logic [TYPE_W-1:0]  ack_type,
   input logic               reg_sel,
   input logic               reg_wr,
   input logic [DATA_W-1:0]  reg_wdata,
   input logic [DATA_W-1:0]  reg_rdata,
   input logic [NUM_TMR-1:0] pend,
   input logic [NUM_TMR-1:0] insvc,
   input logic               dma_halt
);
   logic [NUM_TMR-1:0] a_hit;
   logic               spec_in_range;
   logic [DATA_W-1:0]  rsv_mask;
   logic               cmd_w;

   assign cmd_w = reg_wr && reg_sel;

   always_comb begin
      a_hit         = '0;
      spec_in_range = 1'b0;
      for (int i = 0; i < NUM_TMR; i++) begin
         if (ack_stb && int'(ack_type) == TMR_TYPE_BASE + i) a_hit[i] = 1'b1;
         if (int'(reg_wdata[TYPE_W-1:0]) == TMR_TYPE_BASE + i) spec_in_range = 1'b1;
      end
      rsv_mask = '1;
      rsv_mask[DATA_W-1] = 1'b0;
      if (reg_sel) rsv_mask[TYPE_W-1:0] = '0;
      else         rsv_mask[NUM_TMR-1:0] = '0;
   end

   p_req_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_req != '0) |=> ((pend & $past(tmr_req)) == $past(tmr_req)));

   p_ack_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (a_hit != '0) |=> ((insvc & $past(a_hit)) == $past(a_hit)));

   p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((a_hit & ~tmr_req) != '0) |=> ((pend & $past(a_hit & ~tmr_req)) == '0));

   p_bad_type_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && !reg_wdata[DATA_W-1] && !spec_in_range && a_hit == '0) |=> $stable(insvc));

   p_nspec_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && reg_wdata[DATA_W-1] && a_hit == '0)
      |=> (insvc == ($past(insvc) & ($past(insvc) - NUM_TMR'(1)))));

   p_nmi_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_taken |=> dma_halt);

   p_rsv_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata & rsv_mask) == '0);
endmodule

bind isc_status_eoi isc_status_eoi_chk #(
   .NUM_TMR      (NUM_TMR),
   .TYPE_W       (TYPE_W),
   .TMR_TYPE_BASE(TMR_TYPE_BASE),
   .DATA_W       (DATA_W)
) u_chk (.*);

// File: tb/tb_isc_status_eoi.sv
module tb_isc_status_eoi;
   localparam int N = 3;
   localparam int BASE = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] tmr_req = '0;
   logic        nmi_taken = 1'b0;
   logic        ack_stb = 1'b0;
   logic [4:0]  ack_type = '0;
   logic        reg_sel = 1'b0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [N-1:0] pend;
   logic [N-1:0] insvc;
   logic        dma_halt;

   int errors = 0;
   int checks = 0;
   logic [15:0] rd;

   always #4 clk = ~clk;

   isc_status_eoi dut (
      .clk(clk), .rst_n(rst_n), .tmr_req(tmr_req), .nmi_taken(nmi_taken),
      .ack_stb(ack_stb), .ack_type(ack_type), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pend(pend), .insvc(insvc),
      .dma_halt(dma_halt)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_ack(input int t);
      ack_stb = 1'b1; ack_type = 5'(t);
      step();
      ack_stb = 1'b0;
   endtask

   task automatic wr(input logic sel, input logic [15:0] v);
      reg_sel = sel; reg_wr = 1'b1; reg_wdata = v;
      step();
      reg_wr = 1'b0;
   endtask

   task automatic rdw(input logic sel, output logic [15:0] v);
      reg_sel = sel;
      #1;
      v = reg_rdata;
   endtask

   task automatic clear_all();
      for (int i = 0; i < N; i++) do_ack(BASE + i);
      for (int i = 0; i < N; i++) wr(1'b1, 16'(BASE + i));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 pend", 32'(pend), 0);
      chk("R1 insvc", 32'(insvc), 0);
      chk("R1 halt", 32'(dma_halt), 0);
      rdw(1'b0, rd); chk("R1 status", 32'(rd), 0);
      rdw(1'b1, rd); chk("R1 R11 cmd", 32'(rd), 0);
      rst_n = 1'b1;
      step();

      // R2 / R10: every request pattern
      for (int p = 0; p < 8; p++) begin
         tmr_req = 3'(p);
         step();
         tmr_req = '0;
         chk("R2 pend", 32'(pend), 32'(p));
         rdw(1'b0, rd); chk("R10 status", 32'(rd), 32'(p));
         clear_all();
         chk("R3 pend cleared", 32'(pend), 0);
         chk("R5 insvc cleared", 32'(insvc), 0);
      end

      // R3 single acknowledge, and foreign type
      tmr_req = 3'b111; step(); tmr_req = '0;
      do_ack(BASE + 1);
      chk("R3 pend", 32'(pend), 32'b101);
      chk("R3 insvc", 32'(insvc), 32'b010);
      do_ack(2);
      chk("R3 foreign pend", 32'(pend), 32'b101);
      chk("R3 foreign insvc", 32'(insvc), 32'b010);
      clear_all();

      // R4 request and acknowledge collide
      tmr_req = 3'b001; ack_stb = 1'b1; ack_type = 5'(BASE);
      step();
      tmr_req = '0; ack_stb = 1'b0;
      chk("R4 pend", 32'(pend), 32'b001);
      chk("R4 insvc", 32'(insvc), 32'b001);
      clear_all();

      // R5 / R6 / R11: every specific type
      for (int t = 0; t < 32; t++) begin
         for (int i = 0; i < N; i++) do_ack(BASE + i);
         wr(1'b1, 16'(t));
         if (t >= BASE && t < BASE + N)
            chk("R5 specific", 32'(insvc), 32'(3'b111 & ~(3'b001 << (t - BASE))));
         else
            chk("R6 ignored", 32'(insvc), 32'b111);
         rdw(1'b1, rd); chk("R11 readback", 32'(rd), 32'(t));
      end
      clear_all();

      // R7: every in-service pattern under a nonspecific command
      for (int p = 0; p < 8; p++) begin
         for (int i = 0; i < N; i++) if (p[i]) do_ack(BASE + i);
         chk("R7 setup", 32'(insvc), 32'(p));
         wr(1'b1, 16'h8000);
         chk("R7 nonspecific", 32'(insvc), 32'(p & (p - 1)));
         rdw(1'b1, rd); chk("R11 nspec readback", 32'(rd), 32'h8000);
         clear_all();
      end

      // R12 acknowledge set against command clear
      do_ack(BASE);
      ack_stb = 1'b1; ack_type = 5'(BASE);
      reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 16'(BASE);
      step();
      ack_stb = 1'b0; reg_wr = 1'b0;
      chk("R12 set wins", 32'(insvc), 32'b001);
      clear_all();

      // R8 / R9 DMA suspend flag
      nmi_taken = 1'b1; step(); nmi_taken = 1'b0;
      chk("R8 halt", 32'(dma_halt), 1);
      rdw(1'b0, rd); chk("R8 status bit15", 32'(rd), 32'h8000);
      wr(1'b0, 16'h0000);
      chk("R9 sw clear", 32'(dma_halt), 0);
      wr(1'b0, 16'h8000);
      chk("R9 sw set", 32'(dma_halt), 1);
      nmi_taken = 1'b1; reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = 16'h0000;
      step();
      nmi_taken = 1'b0; reg_wr = 1'b0;
      chk("R9 nmi wins", 32'(dma_halt), 1);
      wr(1'b0, 16'h7FFF);
      chk("R9 halt from bit15", 32'(dma_halt), 0);
      chk("R9 pend untouched", 32'(pend), 0);
      rdw(1'b0, rd); chk("R10 status after write", 32'(rd), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule